// File: doc/BRIEF.md
# Allocate-on-Taken Branch Target Buffer

This block is a small direct-mapped branch target buffer for a fetch unit. Each cycle the fetch stage presents a program counter on the lookup port and gets back, in the same cycle, whether the buffer holds that branch, whether the branch is predicted taken, and the stored target address. When a conditional branch resolves further down the pipeline, its address, its actual direction and its actual target come back on the update port. That update is written at the next rising clock edge.

Each resident entry carries a 2-bit saturating direction state: 0 strongly not taken, 1 weakly not taken, 2 weakly taken, 3 strongly taken. A taken outcome moves the state up by one and a not-taken outcome moves it down by one. The state stops at 0 and at 3. An entry is created only when a branch that is not resident resolves taken. It is written straight into state 3. A branch that is not resident is predicted not taken, so a branch seen for the first time appears to leap from the strongest not-taken state to the strongest taken state.

Top module: `btb_alloc_taken`

## Requirements
- R1: After a synchronous active-low reset, every lookup misses: `lk_hit`=0, `lk_taken`=0 and `lk_target`=0.
- R2: A lookup that misses gives `lk_taken`=0 and `lk_target`=0.
- R3: An update with `up_taken`=1 for a PC that misses allocates the entry. From the next cycle on, a lookup of that PC hits, predicts taken, and returns `up_target`. The entry's state is 3.
- R4: An update with `up_taken`=0 for a PC that misses leaves the buffer unchanged. A later lookup of that PC still misses.
- R5: A lookup that hits predicts taken exactly when the entry's state is 2 or 3. It returns the stored target whatever the predicted direction.
- R6: A taken update that hits raises the state by one. The state saturates at 3.
- R7: A not-taken update that hits lowers the state by one and saturates at 0. Starting from state 3, two not-taken updates are needed before the lookup predicts not taken.
- R8: Starting from state 0, two taken updates are needed before the lookup predicts taken again.
- R9: A taken update that hits rewrites the stored target with `up_target`. A not-taken update keeps the stored target.
- R10: The entry index is PC bits [5:2] (16 entries) and the tag is PC bits [31:6]. A PC with the same index but a different tag misses. Allocating that PC overwrites the entry, so the earlier branch then misses.
- R11: An update takes effect at the clock edge that samples it. A lookup in the same cycle as the update returns the contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | 32 | Fetch PC to look up |
| lk_hit | output | 1 | Lookup PC is resident |
| lk_taken | output | 1 | Predicted taken |
| lk_target | output | 32 | Stored target on a hit, else 0 |
| up_valid | input | 1 | Resolved branch present on the update port |
| up_pc | input | 32 | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_target | input | 32 | Actual target of the branch |

## Verification
One branch is driven through a full walk of its state machine. It is allocated from a miss, pushed up into saturation, walked down two steps at a time to state 0 and past it, and then brought back up. This shows that the saturation points and the two-step hysteresis are correct in both directions. A not-taken resolution on a miss is checked to be a true no-op, which separates allocate-on-taken from allocate-on-any-resolution. Targets are changed on taken hits and held on not-taken hits. A second PC that shares the index but not the tag is used to show tag matching and overwrite on conflict. A third PC is used to show that entries at different indices are independent. A lookup in the same cycle as an update, and a reset in the middle of the run, show the timing of writes and the clearing of the buffer.

// File: rtl/btb_pkg.sv
// Package: shared types for the allocate-on-taken branch target buffer.
// Assumes a 2-bit saturating direction state per entry.
package btb_pkg;
    typedef enum logic [1:0] {
        ST_SNT = 2'd0,
        ST_WNT = 2'd1,
        ST_WT  = 2'd2,
        ST_ST  = 2'd3
    } dir_state_t;
endpackage

// File: rtl/btb_sat_ctr.sv
// Module: next-state and prediction logic for one 2-bit saturating state.
// Purely combinational. Assumes the caller writes nxt only on an update hit.
module btb_sat_ctr
    import btb_pkg::*;
(
    input  dir_state_t cur,
    input  logic       taken,
    output dir_state_t nxt,
    output logic       pred
);
    // Step the state up on taken and down on not taken, stopping at the ends.
    always_comb begin
        nxt = cur;
        if (taken && cur != ST_ST)
            nxt = dir_state_t'(cur + 2'd1);
        else if (!taken && cur != ST_SNT)
            nxt = dir_state_t'(cur - 2'd1);
    end

    // Predict taken in the two upper states.
    assign pred = (cur == ST_WT) || (cur == ST_ST);
endmodule

// File: rtl/btb_entry_array.sv
// Module: direct-mapped entry storage with one combinational read port and
// one registered write port. Allocation happens only on a taken miss.
// Assumes one update at most per cycle. Reads do not see same-cycle writes.
module btb_entry_array
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    parameter int TAG_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output dir_state_t       rd_state,
    output logic [PC_W-1:0]  rd_tgt,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_taken,
    input  logic [PC_W-1:0]  wr_tgt
);
    localparam int N = 1 << IDX_W;

    logic [N-1:0]     valid_vec;
    logic [TAG_W-1:0] tag_arr [N];
    logic [PC_W-1:0]  tgt_arr [N];
    dir_state_t       st_arr  [N];
    logic             wr_hit;

    // Tag compare for the update port.
    assign wr_hit = valid_vec[wr_idx] && (tag_arr[wr_idx] == wr_tag);

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic             v_q;
        logic [TAG_W-1:0] t_q;
        logic [PC_W-1:0]  g_q;
        dir_state_t       s_q;
        dir_state_t       s_nxt;
        logic             s_pred;
        logic             sel;

        assign sel = wr_en && (wr_idx == IDX_W'(i));

        btb_sat_ctr u_ctr (
            .cur   (s_q),
            .taken (wr_taken),
            .nxt   (s_nxt),
            .pred  (s_pred)
        );

        // Entry register: step the state on a hit, allocate on a taken miss.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                t_q <= '0;
                g_q <= '0;
                s_q <= ST_SNT;
            end else if (sel) begin
                if (wr_hit) begin
                    s_q <= s_nxt;
                    if (wr_taken) g_q <= wr_tgt;
                end else if (wr_taken) begin
                    v_q <= 1'b1;
                    t_q <= wr_tag;
                    g_q <= wr_tgt;
                    s_q <= ST_ST;
                end
            end
        end

        assign valid_vec[i] = v_q;
        assign tag_arr[i]   = t_q;
        assign tgt_arr[i]   = g_q;
        assign st_arr[i]    = s_q;
    end

    // Lookup read path.
    assign rd_hit   = valid_vec[rd_idx] && (tag_arr[rd_idx] == rd_tag);
    assign rd_state = st_arr[rd_idx];
    assign rd_tgt   = tgt_arr[rd_idx];

    assert_alloc_strong_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hit && wr_taken) |=>
        (valid_vec[$past(wr_idx)] && st_arr[$past(wr_idx)] == ST_ST));

    assert_nt_miss_noop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hit && !wr_taken) |=> $stable(valid_vec));

    assert_taken_rises_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hit && wr_taken) |=>
        (st_arr[$past(wr_idx)] >= $past(st_arr[wr_idx]) && st_arr[$past(wr_idx)] != ST_SNT));

    assert_nt_falls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hit && !wr_taken) |=>
        (st_arr[$past(wr_idx)] <= $past(st_arr[wr_idx]) && st_arr[$past(wr_idx)] != ST_ST));

    assert_nt_keeps_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hit && !wr_taken) |=>
        (tgt_arr[$past(wr_idx)] == $past(tgt_arr[wr_idx])));
endmodule

// File: rtl/btb_alloc_taken.sv
// Module: top of the branch target buffer. It splits the PCs into index and
// tag, drives the entry array and forms the prediction outputs.
// Assumes word-aligned branch PCs (bits [1:0] ignored).
module btb_alloc_taken
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    parameter int OFS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic            lk_taken,
    output logic [PC_W-1:0] lk_target,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken,
    input  logic [PC_W-1:0] up_target
);
    localparam int TAG_LO = OFS_W + IDX_W;
    localparam int TAG_W  = PC_W - TAG_LO;

    logic             rd_hit;
    dir_state_t       rd_state;
    logic [PC_W-1:0]  rd_tgt;
    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;

    // Field split of both PCs.
    assign lk_idx = lk_pc[TAG_LO-1:OFS_W];
    assign lk_tag = lk_pc[PC_W-1:TAG_LO];
    assign up_idx = up_pc[TAG_LO-1:OFS_W];
    assign up_tag = up_pc[PC_W-1:TAG_LO];

    btb_entry_array #(
        .PC_W  (PC_W),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_tag   (lk_tag),
        .rd_hit   (rd_hit),
        .rd_state (rd_state),
        .rd_tgt   (rd_tgt),
        .wr_en    (up_valid),
        .wr_idx   (up_idx),
        .wr_tag   (up_tag),
        .wr_taken (up_taken),
        .wr_tgt   (up_target)
    );

    // Prediction outputs: a miss is not taken and returns a zero target.
    always_comb begin
        lk_hit    = rd_hit;
        lk_taken  = rd_hit && (rd_state == ST_WT || rd_state == ST_ST);
        lk_target = rd_hit ? rd_tgt : '0;
    end

    assert_taken_resident_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken) ##1 (lk_pc == $past(up_pc)) |-> lk_hit);

    assert_miss_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (!lk_taken && lk_target == '0));
endmodule

// File: tb/sim_btb_alloc_taken.sv
`timescale 1ns/1ps
module sim_btb_alloc_taken;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_hit, lk_taken;
    logic [31:0] lk_target;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic        up_taken = 1'b0;
    logic [31:0] up_target = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    btb_alloc_taken u0 (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit),
        .lk_taken(lk_taken), .lk_target(lk_target), .up_valid(up_valid),
        .up_pc(up_pc), .up_taken(up_taken), .up_target(up_target)
    );

    localparam logic [31:0] PA = 32'h0000_1004; // index 1
    localparam logic [31:0] PX = 32'h0000_2004; // index 1, other tag
    localparam logic [31:0] PB = 32'h0000_1008; // index 2
    localparam logic [31:0] PC = 32'h0000_3010; // index 4
    localparam logic [31:0] T1 = 32'h0000_4000;
    localparam logic [31:0] T2 = 32'h0000_5000;
    localparam logic [31:0] T3 = 32'h0000_6000;

    typedef struct packed {
        logic        uv;
        logic [31:0] upc;
        logic        utk;
        logic [31:0] utg;
        logic [31:0] lpc;
        logic        ehit;
        logic        etk;
        logic [31:0] etg;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1, PA, 1'b0, T1, PA, 1'b0, 1'b0, 32'h0}, // R4 nt miss no alloc
        '{1'b1, PA, 1'b1, T1, PA, 1'b1, 1'b1, T1},    // R3 alloc in state 3
        '{1'b1, PA, 1'b1, T2, PA, 1'b1, 1'b1, T2},    // R6 sat at 3, R9 new target
        '{1'b1, PA, 1'b0, T3, PA, 1'b1, 1'b1, T2},    // R7 3->2, R9 target kept
        '{1'b1, PA, 1'b0, T3, PA, 1'b1, 1'b0, T2},    // R7 2->1 second nt flips
        '{1'b1, PA, 1'b0, T3, PA, 1'b1, 1'b0, T2},    // R7 1->0, R5 target on nt hit
        '{1'b1, PA, 1'b0, T3, PA, 1'b1, 1'b0, T2},    // R7 sat at 0
        '{1'b1, PA, 1'b1, T1, PA, 1'b1, 1'b0, T1},    // R8 0->1 still nt
        '{1'b1, PA, 1'b1, T1, PA, 1'b1, 1'b1, T1},    // R8 1->2 taken, R5
        '{1'b0, PA, 1'b0, 32'h0, PB, 1'b0, 1'b0, 32'h0}, // R2 miss elsewhere
        '{1'b0, PA, 1'b0, 32'h0, PX, 1'b0, 1'b0, 32'h0}, // R10 tag mismatch
        '{1'b1, PX, 1'b1, T3, PA, 1'b0, 1'b0, 32'h0}, // R10 overwrite evicts PA
        '{1'b0, PA, 1'b0, 32'h0, PX, 1'b1, 1'b1, T3}, // R10 new owner hits
        '{1'b1, PB, 1'b1, T2, PB, 1'b1, 1'b1, T2},    // R3 second index
        '{1'b0, PA, 1'b0, 32'h0, PX, 1'b1, 1'b1, T3}  // R10 entries independent
    };

    // Compare all three lookup outputs against expectations as one check.
    task automatic check(input string req, input logic eh, input logic et, input logic [31:0] eg);
        n_chk++;
        if (lk_hit !== eh || lk_taken !== et || lk_target !== eg) begin
            n_fail++;
            $display("FAIL %s: hit/taken/target actual %b/%b/%h expected %b/%b/%h",
                     req, lk_hit, lk_taken, lk_target, eh, et, eg);
        end
    endtask

    // Drive one update and lookup at the falling edge, sample after the rise.
    task automatic step(input logic uv, input logic [31:0] upc, input logic utk,
                        input logic [31:0] utg, input logic [31:0] lpc);
        @(negedge clk);
        up_valid = uv; up_pc = upc; up_taken = utk; up_target = utg; lk_pc = lpc;
        @(posedge clk);
        #2;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        lk_pc = PA;
        #1 check("R1 reset empty", 1'b0, 1'b0, 32'h0);

        for (int k = 0; k < NV; k++) begin
            step(VECS[k].uv, VECS[k].upc, VECS[k].utk, VECS[k].utg, VECS[k].lpc);
            check($sformatf("vector %0d (R2-R10 table)", k), VECS[k].ehit, VECS[k].etk, VECS[k].etg);
        end

        // R11: a same-cycle lookup sees the old contents, the next cycle sees the write.
        @(negedge clk);
        up_valid = 1'b1; up_pc = PC; up_taken = 1'b1; up_target = T1; lk_pc = PC;
        #5 check("R11 same cycle pre-write", 1'b0, 1'b0, 32'h0);
        @(posedge clk);
        #2 check("R11 after edge", 1'b1, 1'b1, T1);
        @(negedge clk);
        up_valid = 1'b0;

        // R1: a reset in mid-run clears every entry.
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        lk_pc = PX;
        #1 check("R1 reset clears PX", 1'b0, 1'b0, 32'h0);
        lk_pc = PB;
        #1 check("R1 reset clears PB", 1'b0, 1'b0, 32'h0);

        finish_run();
    end
endmodule